// File: doc/BRIEF.md
# Peripheral Interrupt Accumulator and Priority Scanner

This block gathers interrupt events from a set of peripheral slots, each slot identified by a small slot number, and merges them into one interrupt line for a single execution environment. Every slot has a status byte. Each bit of that byte is set by a one-cycle pulse on the matching source input. Each slot also has an accumulator enable bit and a write-one-to-clear port. A host reaches the block through a simple register write port and a registered read port.

Servicing is two-level so that the host does not have to poll every status byte. For its environment, the host first reads a 32-bit summary word that carries one bit per slot for a group of 32 slots. It then reads the status byte of each flagged slot. A registered priority scanner already reports the lowest pending enabled slot and the lowest set bit inside that slot. The host can therefore service sources in ascending order straight from the scanner outputs. The scanner can be restricted to a window of summary words, derived from a lowest and a highest slot number.

Top module: `irq_accumulator`

## Requirements
- R1: After reset every status byte and every enable bit is zero, `irq_out` and `scan_valid` are low, and `rd_data` reads zero.
- R2: A pulse on `src_set[s*IRQ_BITS+b]` sets status bit b of slot s at the next clock edge, whether or not that slot is enabled. The status byte of slot s reads back in bits [IRQ_BITS-1:0] at address 0x600 + 4*s. Read data appears on `rd_data` one cycle after `rd_en`.
- R3: Writing bit 0 of the word at address 0x200 + 4*s sets or clears the enable of slot s. The enable reads back in bit 0 of that address.
- R4: Writing a mask to address 0xA00 + 4*s clears exactly the status bits of slot s that are 1 in the mask and leaves the other bits unchanged.
- R5: When a source pulse and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R6: The summary word N of environment ENV_ID is read at address 32*ENV_ID + 4*N. Its bit k is 1 exactly when slot 32*N+k is enabled and has at least one status bit set.
- R7: `irq_out` is the OR of all summary bits. Enabling a slot that already has pending status raises `irq_out` right after the clock edge that performs the write.
- R8: One cycle after any change of state, `scan_valid`, `scan_apid` and `scan_idx` report the lowest-numbered pending enabled slot and the lowest set status bit within it. `scan_valid` is low when nothing qualifies.
- R9: The scanner considers only the slots whose summary word number lies from `scan_win_lo>>5` to `scan_win_hi>>5` inclusive. A slot above `scan_win_hi` but in the same word is still reported. `irq_out` ignores the window.
- R10: A write to a status address or to an unmapped address changes no state. Reads of unmapped addresses, of summary words of other environments and of clear addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_set | input | NUM_APID*IRQ_BITS | One-cycle set pulses, IRQ_BITS per slot |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | DATA_W | Read data, valid the cycle after `rd_en` |
| scan_win_lo | input | APID_W | Lower slot bound of the scan window (word granular) |
| scan_win_hi | input | APID_W | Upper slot bound of the scan window (word granular) |
| irq_out | output | 1 | Combined interrupt for the environment |
| scan_valid | output | 1 | Scanner found a pending enabled source |
| scan_apid | output | APID_W | Lowest pending enabled slot |
| scan_idx | output | IDX_W | Lowest set status bit in that slot |

## Verification
The bench builds the block with NUM_APID = 64 and ENV_ID = 1. This yields two summary words placed away from address zero, so a wrong environment offset or a wrong word stride shows up as misplaced summary bits. With two words, the word-granular scan window can exclude one whole group while keeping the other, and an inverted-looking window whose bounds fall in the same word can be tried. The small slot count also keeps an enable-everything pass short while still giving pending sources spread across both groups for the ordering walk.

// File: rtl/irqacc_pkg.sv
package irqacc_pkg;
  // Register region bases (byte addresses)
  localparam int EN_BASE    = 'h200;
  localparam int STAT_BASE  = 'h600;
  localparam int CLR_BASE   = 'hA00;
  // Summary words: one per group of slots, stride per environment
  localparam int GRP_SLOTS  = 32;
  localparam int GRP_SH     = 5;
  localparam int ENV_STRIDE = 32;
endpackage

// File: rtl/irqacc_slot.sv
module irqacc_slot #(
  parameter int IRQ_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IRQ_BITS-1:0] set_i,
  input  logic                clr_we_i,
  input  logic [IRQ_BITS-1:0] clr_mask_i,
  input  logic                en_we_i,
  input  logic                en_d_i,
  output logic [IRQ_BITS-1:0] status_o,
  output logic                en_o
);
  logic [IRQ_BITS-1:0] status_q, status_d;
  logic                stat_ce;
  logic                en_q;

  // next state: clear first, then set so that a colliding set survives
  always_comb begin
    status_d = status_q;
    if (clr_we_i) status_d = status_d & ~clr_mask_i;
    status_d = status_d | set_i;
    stat_ce  = clr_we_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (stat_ce) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_we_i) begin
      en_q <= en_d_i;
    end
  end

  assign status_o = status_q;
  assign en_o     = en_q;
endmodule

// File: rtl/irqacc_scan.sv
module irqacc_scan
  import irqacc_pkg::*;
#(
  parameter int NUM_APID = 256,
  parameter int IRQ_BITS = 8,
  localparam int APID_W  = $clog2(NUM_APID),
  localparam int IDX_W   = $clog2(IRQ_BITS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_APID-1:0]          pend_i,
  input  logic [NUM_APID*IRQ_BITS-1:0] status_i,
  input  logic [APID_W-1:0]            win_lo_i,
  input  logic [APID_W-1:0]            win_hi_i,
  output logic                         valid_o,
  output logic [APID_W-1:0]            apid_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [APID_W-1:0]   lo_word, hi_word;
  logic [NUM_APID-1:0] in_win;
  logic                hit_n;
  logic [APID_W-1:0]   apid_n;
  logic [IRQ_BITS-1:0] sel;
  logic [IDX_W-1:0]    idx_n;
  logic                valid_q;
  logic [APID_W-1:0]   apid_q;
  logic [IDX_W-1:0]    idx_q;

  assign lo_word = win_lo_i >> GRP_SH;
  assign hi_word = win_hi_i >> GRP_SH;

  for (genvar g = 0; g < NUM_APID; g++) begin : g_win
    localparam logic [APID_W-1:0] SLOT_NUM = APID_W'(g);
    assign in_win[g] = ((SLOT_NUM >> GRP_SH) >= lo_word) &&
                       ((SLOT_NUM >> GRP_SH) <= hi_word);
  end

  // lowest slot first, then lowest bit within the slot
  always_comb begin
    hit_n  = 1'b0;
    apid_n = '0;
    for (int a = NUM_APID-1; a >= 0; a--) begin
      if (pend_i[a] && in_win[a]) begin
        hit_n  = 1'b1;
        apid_n = APID_W'(a);
      end
    end
    sel   = status_i[apid_n*IRQ_BITS +: IRQ_BITS];
    idx_n = '0;
    for (int b = IRQ_BITS-1; b >= 0; b--) begin
      if (sel[b]) idx_n = IDX_W'(b);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      apid_q  <= '0;
      idx_q   <= '0;
    end else begin
      valid_q <= hit_n;
      apid_q  <= apid_n;
      idx_q   <= idx_n;
    end
  end

  assign valid_o = valid_q;
  assign apid_o  = apid_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/irq_accumulator.sv
module irq_accumulator
  import irqacc_pkg::*;
#(
  parameter int NUM_APID = 256,
  parameter int IRQ_BITS = 8,
  parameter int ENV_ID   = 0,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  localparam int APID_W  = $clog2(NUM_APID),
  localparam int IDX_W   = $clog2(IRQ_BITS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_APID*IRQ_BITS-1:0] src_set,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  input  logic [APID_W-1:0]            scan_win_lo,
  input  logic [APID_W-1:0]            scan_win_hi,
  output logic                         irq_out,
  output logic                         scan_valid,
  output logic [APID_W-1:0]            scan_apid,
  output logic [IDX_W-1:0]             scan_idx
);
  localparam int NUM_WORDS = NUM_APID / GRP_SLOTS;
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int OWN_BASE  = ENV_STRIDE * ENV_ID;

  logic [NUM_APID*IRQ_BITS-1:0] stat_flat;
  logic [NUM_APID-1:0]          en_vec;
  logic [NUM_APID-1:0]          pend;
  logic                         en_hit, clr_hit;
  logic [APID_W-1:0]            en_slot, clr_slot;
  logic [DATA_W-1:0]            rd_next, rd_q;
  logic                         unused_wdata;

  function automatic logic in_slot_region(input logic [ADDR_W-1:0] a, input int base);
    return (int'(a) >= base) && (int'(a) < base + 4*NUM_APID) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [APID_W-1:0] slot_of(input logic [ADDR_W-1:0] a, input int base);
    return APID_W'((int'(a) - base) / 4);
  endfunction

  function automatic logic in_own_region(input logic [ADDR_W-1:0] a);
    return (int'(a) >= OWN_BASE) && (int'(a) < OWN_BASE + 4*NUM_WORDS) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return WORD_W'((int'(a) - OWN_BASE) / 4);
  endfunction

  // write decode
  always_comb begin
    en_hit   = wr_en && in_slot_region(wr_addr, EN_BASE);
    clr_hit  = wr_en && in_slot_region(wr_addr, CLR_BASE);
    en_slot  = slot_of(wr_addr, EN_BASE);
    clr_slot = slot_of(wr_addr, CLR_BASE);
  end

  assign unused_wdata = ^wr_data[DATA_W-1:IRQ_BITS];

  for (genvar s = 0; s < NUM_APID; s++) begin : g_slot
    irqacc_slot #(.IRQ_BITS(IRQ_BITS)) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (src_set[s*IRQ_BITS +: IRQ_BITS]),
      .clr_we_i  (clr_hit && (clr_slot == APID_W'(s))),
      .clr_mask_i(wr_data[IRQ_BITS-1:0]),
      .en_we_i   (en_hit && (en_slot == APID_W'(s))),
      .en_d_i    (wr_data[0]),
      .status_o  (stat_flat[s*IRQ_BITS +: IRQ_BITS]),
      .en_o      (en_vec[s])
    );
    assign pend[s] = en_vec[s] & (|stat_flat[s*IRQ_BITS +: IRQ_BITS]);
  end

  assign irq_out = |pend;

  // read mux
  always_comb begin
    rd_next = '0;
    if (in_own_region(rd_addr)) begin
      rd_next[GRP_SLOTS-1:0] = pend[word_of(rd_addr)*GRP_SLOTS +: GRP_SLOTS];
    end else if (in_slot_region(rd_addr, EN_BASE)) begin
      rd_next[0] = en_vec[slot_of(rd_addr, EN_BASE)];
    end else if (in_slot_region(rd_addr, STAT_BASE)) begin
      rd_next[IRQ_BITS-1:0] = stat_flat[slot_of(rd_addr, STAT_BASE)*IRQ_BITS +: IRQ_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_next;
    end
  end

  assign rd_data = rd_q;

  irqacc_scan #(.NUM_APID(NUM_APID), .IRQ_BITS(IRQ_BITS)) scan_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend),
    .status_i(stat_flat),
    .win_lo_i(scan_win_lo),
    .win_hi_i(scan_win_hi),
    .valid_o (scan_valid),
    .apid_o  (scan_apid),
    .idx_o   (scan_idx)
  );
endmodule

// File: rtl/irq_accumulator_chk.sv
module irq_accumulator_chk #(
  parameter int NUM_APID = 256,
  parameter int IRQ_BITS = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_APID*IRQ_BITS-1:0] src_set,
  input logic                         wr_en,
  input logic [NUM_APID*IRQ_BITS-1:0] stat_flat,
  input logic [NUM_APID-1:0]          en_vec,
  input logic                         irq_out,
  input logic                         scan_valid
);
  logic [NUM_APID-1:0] nz;
  always_comb begin
    for (int a = 0; a < NUM_APID; a++) nz[a] = |stat_flat[a*IRQ_BITS +: IRQ_BITS];
  end

  // R2 / R5: every pulsed bit is set after the edge, even against a clear
  p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((stat_flat & $past(src_set)) == $past(src_set)));

  // R4: a status bit can only fall through a register write
  p_fall_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat_flat) & ~stat_flat) != '0) |-> $past(wr_en));

  // R7: combined line tracks enabled, non-empty slots
  p_irq_tracks_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(en_vec & nz));

  // R8: a reported source existed in the previous cycle
  p_scan_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid |-> $past(irq_out));
endmodule

bind irq_accumulator irq_accumulator_chk #(.NUM_APID(NUM_APID), .IRQ_BITS(IRQ_BITS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_set   (src_set),
  .wr_en     (wr_en),
  .stat_flat (stat_flat),
  .en_vec    (en_vec),
  .irq_out   (irq_out),
  .scan_valid(scan_valid)
);

// File: tb/irq_accumulator_tb_top.sv
module irq_accumulator_tb_top;
  localparam int NA = 64;
  localparam int NB = 8;
  localparam int AW = 6;

  logic            clk;
  logic            rst_n;
  logic [NA*NB-1:0] src_set;
  logic            wr_en, rd_en;
  logic [11:0]     wr_addr, rd_addr;
  logic [31:0]     wr_data, rd_data;
  logic [AW-1:0]   win_lo, win_hi;
  logic            irq_out, scan_valid;
  logic [AW-1:0]   scan_apid;
  logic [2:0]      scan_idx;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  irq_accumulator #(.NUM_APID(NA), .IRQ_BITS(NB), .ENV_ID(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_set(src_set),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .scan_win_lo(win_lo), .scan_win_hi(win_hi),
    .irq_out(irq_out), .scan_valid(scan_valid),
    .scan_apid(scan_apid), .scan_idx(scan_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [11:0] a_en(int s);   return 12'(32'h200 + 4*s); endfunction
  function automatic logic [11:0] a_stat(int s); return 12'(32'h600 + 4*s); endfunction
  function automatic logic [11:0] a_clr(int s);  return 12'(32'hA00 + 4*s); endfunction
  function automatic logic [11:0] a_own(int w);  return 12'(32 + 4*w); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(int s, logic [7:0] m);
    @(negedge clk); src_set[s*NB +: NB] = m;
    @(posedge clk);
    @(negedge clk); src_set = '0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_scan(string req, logic v, int s, int ix);
    chk({req, " valid"}, 32'(scan_valid), 32'(v));
    if (v) begin
      chk({req, " apid"}, 32'(scan_apid), 32'(s));
      chk({req, " idx"}, 32'(scan_idx), 32'(ix));
    end
  endtask

  // op(1) slot(8) mask(8) exp_valid(1) exp_slot(8) exp_idx(3)
  localparam logic [28:0] VEC [8] = '{
    {1'b0, 8'd40, 8'h10, 1'b1, 8'd40, 3'd4},
    {1'b0, 8'd40, 8'h02, 1'b1, 8'd40, 3'd1},
    {1'b0, 8'd7,  8'h80, 1'b1, 8'd7,  3'd7},
    {1'b0, 8'd33, 8'h01, 1'b1, 8'd7,  3'd7},
    {1'b1, 8'd7,  8'h80, 1'b1, 8'd33, 3'd0},
    {1'b1, 8'd33, 8'h01, 1'b1, 8'd40, 3'd1},
    {1'b1, 8'd40, 8'h02, 1'b1, 8'd40, 3'd4},
    {1'b1, 8'd40, 8'h10, 1'b0, 8'd0,  3'd0}
  };

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src_set = '0; wr_en = 0; rd_en = 0;
    wr_addr = '0; rd_addr = '0; wr_data = '0; win_lo = '0; win_hi = AW'(NA-1);
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq_out), 0);
    chk("R1 scan_valid", 32'(scan_valid), 0);
    chk("R1 rd_data", rd_data, 0);
    rd(a_stat(5), d); chk("R1 status", d, 0);
    rd(a_en(5), d);   chk("R1 enable", d, 0);

    // R2 pulse with enable clear
    pulse(10, 8'h08);
    rd(a_stat(10), d); chk("R2 status set while disabled", d, 32'h08);
    chk("R2 irq stays low", 32'(irq_out), 0);
    settle(); chk_scan("R2 scan", 1'b0, 0, 0);

    // R7 / R3 enabling a pending slot
    wr(a_en(10), 32'h1);
    chk("R7 irq next cycle", 32'(irq_out), 1);
    rd(a_en(10), d); chk("R3 enable readback", d, 1);
    rd(a_own(0), d); chk("R6 summary word0", d, 32'h400);
    wr(a_clr(10), 32'hFF);
    rd(a_stat(10), d); chk("R4 full clear", d, 0);
    chk("R7 irq drops", 32'(irq_out), 0);

    for (int s = 0; s < NA; s++) wr(a_en(s), 32'h1);

    // R8 ordering walk
    foreach (VEC[i]) begin
      if (VEC[i][28]) wr(a_clr(int'(VEC[i][27:20])), 32'(VEC[i][19:12]));
      else pulse(int'(VEC[i][27:20]), VEC[i][19:12]);
      settle();
      chk_scan("R8 walk", VEC[i][11], int'(VEC[i][10:3]), int'(VEC[i][2:0]));
      chk("R7 walk irq", 32'(irq_out), 32'(VEC[i][11]));
    end

    // R5 collision: set wins
    @(negedge clk);
    src_set[3*NB + 2] = 1'b1; wr_en = 1'b1; wr_addr = a_clr(3); wr_data = 32'h04;
    @(posedge clk);
    @(negedge clk); src_set = '0; wr_en = 1'b0;
    rd(a_stat(3), d); chk("R5 set beats clear", d, 32'h04);

    // R4 partial clear
    pulse(3, 8'h01);
    wr(a_clr(3), 32'h01);
    rd(a_stat(3), d); chk("R4 partial clear", d, 32'h04);
    wr(a_clr(3), 32'h04);

    // R9 window
    @(negedge clk); win_lo = AW'(0); win_hi = AW'(20);
    pulse(50, 8'h40);
    settle();
    chk_scan("R9 out of window", 1'b0, 0, 0);
    chk("R9 irq ignores window", 32'(irq_out), 1);
    pulse(5, 8'h02);
    settle(); chk_scan("R9 in window", 1'b1, 5, 1);
    @(negedge clk); win_lo = AW'(40); win_hi = AW'(33);
    settle(); chk_scan("R9 word granular", 1'b1, 50, 6);
    @(negedge clk); win_lo = AW'(0); win_hi = AW'(NA-1);
    settle(); chk_scan("R8 full window", 1'b1, 5, 1);

    // R6 summary words
    rd(a_own(1), d); chk("R6 summary word1", d, 32'h0004_0000);
    rd(a_own(0), d); chk("R6 summary word0", d, 32'h20);

    // R10 ignored accesses
    rd(12'h000, d); chk("R10 other env word", d, 0);
    rd(12'h100, d); chk("R10 unmapped read", d, 0);
    rd(a_clr(50), d); chk("R10 clear reads zero", d, 0);
    wr(a_stat(50), 32'hFF);
    wr(12'hE00, 32'hFF);
    rd(a_stat(50), d); chk("R10 status write ignored", d, 32'h40);
    rd(a_stat(5), d);  chk("R10 unmapped write ignored", d, 32'h02);

    // R3 disable masks summary, keeps status
    wr(a_en(50), 32'h0);
    rd(a_own(1), d);   chk("R3 disabled summary", d, 0);
    rd(a_stat(50), d); chk("R3 status kept", d, 32'h40);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule